// File: doc/BRIEF.md
# Pre-Indexed Indirect Address Generator

This unit produces a 24-bit effective address for a pre-indexed indirect addressing mode. A one-cycle `start` pulse captures four inputs: an 8-bit instruction offset, a 16-bit direct base, a 16-bit X index and an 8-bit data bank. The unit adds the offset, the base and the index modulo 2^16. The result is a pointer location that always lies in bank zero.

The unit then reads a 16-bit little-endian pointer from that location through a byte-wide read port. It reads the low byte first, then the high byte at the next location. The second read address wraps within bank zero. Each read is one request pulse, followed some cycles later by a returned byte on `rd_valid`/`rd_data`. Only one read is outstanding at a time.

When the high byte arrives, the unit forms the effective address. The bank byte comes from the captured data bank, and the lower 16 bits come from the fetched pointer. The unit presents this address with a one-cycle `ea_valid` pulse and holds it until the next result.

Top module: `aig_indexed_indirect`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `rd_req` and `ea_valid` are 0 and `ea` is 0.
- R2: In the cycle after an accepted `start`, `rd_req` is 1 and `rd_addr[15:0]` equals (offset + dir_base + x_index) mod 2^16.
- R3: `rd_addr[23:16]` is always 0x00. The 16-bit pointer sum never carries into the bank byte.
- R4: In the cycle after the low byte returns, `rd_req` is 1 again and `rd_addr[15:0]` equals the pointer location plus one, mod 2^16 (0xFFFF is followed by 0x0000).
- R5: Each read request lasts exactly one cycle. No new request is issued until the data for the previous one has returned.
- R6: In the cycle after the high byte returns, `ea_valid` is 1 for exactly one cycle. At that time `ea` = {data_bank, high byte, low byte}.
- R7: The inputs are captured only at an accepted `start`. Changing them later has no effect on the result in progress.
- R8: `busy` is 1 from the cycle after an accepted `start` through the `ea_valid` cycle. A `start` pulse seen while `busy` is 1 is ignored.
- R9: A `rd_valid` pulse seen while no read is awaiting data is ignored. This includes the cycle in which a request is issued and any cycle while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address generation (accepted when idle) |
| offset | input | 8 | Instruction offset byte |
| dir_base | input | 16 | Direct base register value |
| x_index | input | 16 | X index register value |
| data_bank | input | 8 | Data bank register value |
| busy | output | 1 | Generation in progress |
| rd_req | output | 1 | One-cycle byte read request |
| rd_addr | output | 24 | Byte read address (bank zero) |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 8 | Returned read byte |
| ea | output | 24 | Effective address |
| ea_valid | output | 1 | One-cycle strobe marking a new `ea` |

## Verification
A corrupted captured pointer shows up on `rd_addr` in the first cycle after `start`, well before any result appears. A sequencer stuck in the wrong phase shows up one cycle after a byte returns. It appears as a missing or repeated `rd_req`, or as `ea_valid` firing early or twice. A wrongly captured bank byte or low byte is visible only in `ea` during the `ea_valid` cycle. For that reason every result is compared there against a model that uses random read latencies, stray `rd_valid` pulses and input changes made while the unit is busy.

// File: rtl/aig_pkg.sv
package aig_pkg;

  // Sequencer phases of one address generation
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ_LO  = 3'd1,
    ST_WAIT_LO = 3'd2,
    ST_REQ_HI  = 3'd3,
    ST_WAIT_HI = 3'd4,
    ST_DONE    = 3'd5
  } aig_state_e;

endpackage

// File: rtl/aig_ptr_sum.sv
module aig_ptr_sum #(
  parameter int OFS_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFS_W-1:0]  offset,
  input  logic [WORD_W-1:0] dir_base,
  input  logic [WORD_W-1:0] x_index,
  output logic [WORD_W-1:0] ptr_q
);

  // Three-term sum, truncated to the word width (no carry out)
  function automatic logic [WORD_W-1:0] ptr_sum(
    input logic [OFS_W-1:0]  ofs,
    input logic [WORD_W-1:0] base,
    input logic [WORD_W-1:0] idx
  );
    return WORD_W'(ofs) + base + idx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= ptr_sum(offset, dir_base, x_index);
  end

endmodule

// File: rtl/aig_fetch_seq.sv
module aig_fetch_seq
  import aig_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BANK_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     rd_valid,
  input  logic [WORD_W-1:0]        ptr,
  output logic                     busy,
  output logic                     accept,
  output logic                     rd_req,
  output logic                     lo_take,
  output logic                     hi_take,
  output logic                     ea_fire,
  output logic [BANK_W+WORD_W-1:0] rd_addr
);

  localparam logic [BANK_W-1:0] ZERO_BANK = '0;

  function automatic logic [WORD_W-1:0] ptr_step(input logic [WORD_W-1:0] p);
    return p + WORD_W'(1);
  endfunction

  aig_state_e state_q, state_d;

  assign busy    = (state_q != ST_IDLE);
  assign accept  = start && !busy;
  assign rd_req  = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
  assign lo_take = (state_q == ST_WAIT_LO) && rd_valid;
  assign hi_take = (state_q == ST_WAIT_HI) && rd_valid;
  assign ea_fire = (state_q == ST_DONE);
  assign rd_addr = {ZERO_BANK, (state_q == ST_REQ_HI) ? ptr_step(ptr) : ptr};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_REQ_LO;
      ST_REQ_LO:  state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (rd_valid) state_d = ST_REQ_HI;
      ST_REQ_HI:  state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (rd_valid) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R5
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R9
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !ea_fire);

  // R6
  fire_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_fire |=> !ea_fire);

endmodule

// File: rtl/aig_ea_join.sv
module aig_ea_join #(
  parameter int WORD_W = 16,
  parameter int BANK_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bank_load,
  input  logic [BANK_W-1:0]        bank_in,
  input  logic                     lo_take,
  input  logic                     hi_take,
  input  logic [WORD_W/2-1:0]      rd_data,
  input  logic                     ea_fire,
  output logic [BANK_W+WORD_W-1:0] ea,
  output logic                     ea_valid
);

  localparam int BYTE_W = WORD_W / 2;

  // Little-endian join of bank, high byte and low byte
  function automatic logic [BANK_W+WORD_W-1:0] ea_join(
    input logic [BANK_W-1:0] bank,
    input logic [BYTE_W-1:0] hi,
    input logic [BYTE_W-1:0] lo
  );
    return {bank, hi, lo};
  endfunction

  logic [BANK_W-1:0] bank_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      lo_q   <= '0;
      ea     <= '0;
    end else begin
      if (bank_load) bank_q <= bank_in;
      if (lo_take)   lo_q   <= rd_data;
      if (hi_take)   ea     <= ea_join(bank_q, rd_data, lo_q);
    end
  end

  assign ea_valid = ea_fire;

  // R6
  ea_bank_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> ea[BANK_W+WORD_W-1:WORD_W] == bank_q);

  // R6
  ea_hi_from_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_take |=> ea[WORD_W-1:BYTE_W] == $past(rd_data));

endmodule

// File: rtl/aig_indexed_indirect.sv
module aig_indexed_indirect #(
  parameter int OFS_W  = 8,
  parameter int WORD_W = 16,
  parameter int BANK_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [OFS_W-1:0]         offset,
  input  logic [WORD_W-1:0]        dir_base,
  input  logic [WORD_W-1:0]        x_index,
  input  logic [BANK_W-1:0]        data_bank,
  output logic                     busy,
  output logic                     rd_req,
  output logic [BANK_W+WORD_W-1:0] rd_addr,
  input  logic                     rd_valid,
  input  logic [WORD_W/2-1:0]      rd_data,
  output logic [BANK_W+WORD_W-1:0] ea,
  output logic                     ea_valid
);

  logic              accept;
  logic              lo_take;
  logic              hi_take;
  logic              ea_fire;
  logic [WORD_W-1:0] ptr_q;

  aig_ptr_sum #(.OFS_W(OFS_W), .WORD_W(WORD_W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .offset   (offset),
    .dir_base (dir_base),
    .x_index  (x_index),
    .ptr_q    (ptr_q)
  );

  aig_fetch_seq #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_valid (rd_valid),
    .ptr      (ptr_q),
    .busy     (busy),
    .accept   (accept),
    .rd_req   (rd_req),
    .lo_take  (lo_take),
    .hi_take  (hi_take),
    .ea_fire  (ea_fire),
    .rd_addr  (rd_addr)
  );

  aig_ea_join #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_join (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_load (accept),
    .bank_in   (data_bank),
    .lo_take   (lo_take),
    .hi_take   (hi_take),
    .rd_data   (rd_data),
    .ea_fire   (ea_fire),
    .ea        (ea),
    .ea_valid  (ea_valid)
  );

  // R2
  first_req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_req && rd_addr[WORD_W-1:0] == ptr_q);

  // R4
  second_req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_take |=> rd_req && rd_addr[WORD_W-1:0] == ($past(ptr_q) + WORD_W'(1)));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(ptr_q));

  // R3
  req_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[BANK_W+WORD_W-1:WORD_W] == '0);

endmodule

// File: tb/aig_indexed_indirect_tb.sv
module aig_indexed_indirect_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  offset = '0;
  logic [15:0] dir_base = '0;
  logic [15:0] x_index = '0;
  logic [7:0]  data_bank = '0;
  logic        busy;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic [23:0] ea;
  logic        ea_valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  aig_indexed_indirect u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset),
    .dir_base(dir_base), .x_index(x_index), .data_bank(data_bank),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .ea(ea), .ea_valid(ea_valid)
  );

  // Memory content model: a scrambled byte per address
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'd40503;
    return m[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  // Pointer location computed as a 17+ bit sum, then folded into bank zero
  function automatic logic [15:0] exp_loc(input logic [7:0] o, input logic [15:0] b,
                                          input logic [15:0] x);
    logic [17:0] wide;
    wide = {10'd0, o} + {2'd0, b} + {2'd0, x};
    return wide[15:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] o, input logic [15:0] b, input logic [15:0] x,
                        input logic [7:0] bank, input int lat_lo, input int lat_hi,
                        input bit noise);
    logic [15:0] loc, loc1;
    logic [7:0]  lo_b, hi_b;
    logic [23:0] exp_ea;
    loc    = exp_loc(o, b, x);
    loc1   = loc + 16'd1;
    lo_b   = mem_byte(loc);
    hi_b   = mem_byte(loc1);
    exp_ea = {bank, hi_b, lo_b};

    @(negedge clk);
    start = 1'b1; offset = o; dir_base = b; x_index = x; data_bank = bank;
    @(negedge clk);
    start = 1'b0;
    // R7: scramble inputs once captured
    offset = 8'($urandom); dir_base = 16'($urandom); x_index = 16'($urandom);
    data_bank = 8'($urandom);
    chk(rd_req === 1'b1 && rd_addr === {8'h00, loc}, "R2 first read", {7'd0, rd_req, rd_addr},
        {8'd1, 8'h00, loc});
    chk(busy === 1'b1, "R8 busy after start", {31'd0, busy}, 32'd1);
    if (noise) begin
      rd_valid = 1'b1; rd_data = 8'($urandom);  // R9: returned in request cycle
    end
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_req === 1'b0, "R5 single request", {31'd0, rd_req}, 32'd0);
    start = 1'b1;  // R8: start while busy
    offset = 8'($urandom); dir_base = 16'($urandom); x_index = 16'($urandom);
    for (int i = 0; i < lat_lo; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk(rd_req === 1'b0, "R5 no request while waiting", {31'd0, rd_req}, 32'd0);
    end
    rd_valid = 1'b1; rd_data = lo_b;
    @(negedge clk);
    rd_valid = 1'b0; start = 1'b0;
    chk(rd_req === 1'b1 && rd_addr === {8'h00, loc1}, "R4 second read",
        {7'd0, rd_req, rd_addr}, {8'd1, 8'h00, loc1});
    chk(rd_addr[23:16] === 8'h00, "R3 bank zero", {24'd0, rd_addr[23:16]}, 32'd0);
    @(negedge clk);
    chk(rd_req === 1'b0, "R5 single second request", {31'd0, rd_req}, 32'd0);
    for (int i = 0; i < lat_hi; i++) begin
      @(negedge clk);
      chk(ea_valid === 1'b0, "R6 no early strobe", {31'd0, ea_valid}, 32'd0);
    end
    rd_valid = 1'b1; rd_data = hi_b;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(ea_valid === 1'b1 && ea === exp_ea, "R6 R7 effective address",
        {7'd0, ea_valid, ea}, {8'd1, exp_ea});
    @(negedge clk);
    chk(ea_valid === 1'b0 && busy === 1'b0, "R6 R8 strobe ends", {30'd0, ea_valid, busy}, 32'd0);
    chk(ea === exp_ea, "R6 ea held", {8'd0, ea}, {8'd0, exp_ea});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd9137));
    repeat (2) @(negedge clk);
    // R1: state during reset
    chk(busy === 1'b0 && rd_req === 1'b0 && ea_valid === 1'b0 && ea === 24'd0,
        "R1 in reset", {5'd0, busy, rd_req, ea_valid, ea}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && rd_req === 1'b0 && ea_valid === 1'b0 && ea === 24'd0,
        "R1 after reset", {5'd0, busy, rd_req, ea_valid, ea}, 32'd0);

    // R3: sum wraps without reaching the bank byte
    run_op(8'hFF, 16'hFFFF, 16'hFFFF, 8'h7E, 0, 0, 1'b0);
    // R4: pointer at top of bank zero, next byte at 0x0000
    run_op(8'h00, 16'hFFFF, 16'h0000, 8'hC3, 1, 2, 1'b0);
    run_op(8'h00, 16'h0000, 16'h0000, 8'h00, 3, 0, 1'b1);
    run_op(8'h01, 16'hFF00, 16'h00FE, 8'hFF, 2, 1, 1'b1);

    // R9: stray data returns while idle
    @(negedge clk);
    rd_valid = 1'b1; rd_data = 8'hEE;
    @(negedge clk);
    @(negedge clk);
    chk(rd_req === 1'b0 && ea_valid === 1'b0 && busy === 1'b0, "R9 idle stray data",
        {29'd0, rd_req, ea_valid, busy}, 32'd0);
    rd_valid = 1'b0;
    chk(ea === {8'hFF, mem_byte(16'h0000), mem_byte(16'hFFFF)}, "R9 ea untouched",
        {8'd0, ea}, {8'd0, 8'hFF, mem_byte(16'h0000), mem_byte(16'hFFFF)});

    for (int n = 0; n < 40; n++) begin
      run_op(8'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
             int'($urandom % 4), int'($urandom % 4), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule